// File: doc/BRIEF.md
# Serial Flash Sector-Erase Command Controller

This block is the target-side command logic of a serial flash device for the sector-erase operation. It watches a mode-0 SPI link (chip select active low, serial clock, serial data in), oversamples it in the system clock domain, and assembles each frame that arrives while chip select is low. A one-byte write-enable frame arms a latch. A four-byte erase frame (opcode plus 24-bit address) then issues an erase request for the addressed 64 KiB sector. The request is only issued if the frame ended on exactly the right bit and the latch is set. The sector must also be free of hardware protection, and no cycle may already be running.

Once an erase is accepted, a self-timed cycle runs for a parameterised number of system clocks. The write-in-progress flag is high for the whole cycle. The write-enable latch is dropped one clock before the flag falls. A read-status frame shifts a snapshot of both flags back out on the serial data output. The same two flags are also presented in parallel on a status port.

Top module: `sectorEraseCtl`

## Requirements
- R1: An erase frame that completes while the write-enable latch is 0 produces no erase request and no busy cycle.
- R2: A frame of exactly 8 bits carrying opcode 06h, followed by chip select rising, sets the write-enable latch.
- R3: Bits are sampled MSB first on rising serial clock edges while chip select is low. An erase frame (opcode D8h then a 24-bit address) takes effect only if chip select rises after exactly 32 bits. Any other bit count is discarded and leaves the write-enable latch unchanged.
- R4: The sector index reported with the request is address bits 20 to 16. Address bits 23 to 21 are ignored.
- R5: An accepted erase raises eraseReq for exactly one clock with eraseSector valid, and raises busy in the same clock. Busy stays high for exactly ERASE_CYCLES clocks. Both take effect on the third system clock rising edge after chip select rises.
- R6: The write-enable latch clears exactly one clock before busy falls at the end of an erase cycle.
- R7: An erase frame addressing a sector whose hwProt bit is 1 is not executed and leaves the write-enable latch unchanged.
- R8: statusOut is {6'b0, latch, busy}, with the write-enable latch in bit 1 and write-in-progress in bit 0. After an 8-bit 05h opcode, the status byte as it stood at the eighth rising edge is driven MSB first on miso, with each bit changing after a falling serial clock edge. miso is 0 at all other times.
- R9: An erase frame arriving while busy is ignored and does not change the length of the running cycle.
- R10: After reset, statusOut, busy, eraseReq and miso are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock (mode 0) |
| mosi | input | 1 | SPI serial data in |
| hwProt | input | NUM_SECT | Per-sector hardware-protect flags |
| miso | output | 1 | SPI serial data out (status readback) |
| eraseReq | output | 1 | One-clock erase request strobe |
| eraseSector | output | $clog2(NUM_SECT) | Sector index for the request |
| busy | output | 1 | Erase cycle in progress |
| statusOut | output | 8 | Status byte {6'b0, write-enable latch, busy} |

## Verification
The effect of every frame appears on the third system clock edge after chip select rises. That delay is two synchroniser stages plus the registered decision. The bench's behavioural model therefore queues each frame's outcome for the cycle three edges after the one in which the bench raised chip select. It then compares busy, status, request and sector at every falling clock edge. The model counts a busy cycle as exactly ERASE_CYCLES clocks and drops the latch one clock earlier. Readback bits on miso are due within three clocks of each falling serial clock edge, so the bench holds every serial clock phase for four system clocks and samples miso just before the next rising edge.

// File: rtl/secErasePkg.sv
package secErasePkg;

  // Command opcodes
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_SE   = 8'hD8;

  // Strobes raised by the datapath when a frame closes correctly
  typedef struct packed {
    logic wrenStb;
    logic eraseStb;
  } frameEvt_t;

endpackage

// File: rtl/spiFrameDp.sv
module spiFrameDp
  import secErasePkg::*;
#(
  parameter int NUM_SECT   = 32,
  parameter int SECT_LSB   = 16,
  parameter int FRAME_BITS = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        csN,
  input  logic                        sclk,
  input  logic                        mosi,
  input  logic [7:0]                  statusByte,
  output frameEvt_t                   evt,
  output logic [$clog2(NUM_SECT)-1:0] sector,
  output logic                        miso
);

  localparam int SECT_W = $clog2(NUM_SECT);
  localparam int CNT_W  = $clog2(FRAME_BITS + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_SAT   = '1;
  localparam logic [CNT_W-1:0] CNT_FRAME = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_BYTE  = CNT_W'(8);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(7);

  // Two-stage synchronisers for the link
  logic [1:0] csSync, sclkSync, mosiSync;
  logic       csPrev, sclkPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csSync   <= 2'b11;
      sclkSync <= 2'b00;
      mosiSync <= 2'b00;
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csSync   <= {csSync[0], csN};
      sclkSync <= {sclkSync[0], sclk};
      mosiSync <= {mosiSync[0], mosi};
      csPrev   <= csSync[1];
      sclkPrev <= sclkSync[1];
    end
  end

  logic csS, sclkS, mosiS;
  logic sclkRise, sclkFall, csRise;
  assign csS      = csSync[1];
  assign sclkS    = sclkSync[1];
  assign mosiS    = mosiSync[1];
  assign sclkRise = !csS && sclkS && !sclkPrev;
  assign sclkFall = !csS && !sclkS && sclkPrev;
  assign csRise   = csS && !csPrev;

  // Bit counter and input shifter
  logic [CNT_W-1:0]      bitCnt;
  logic [FRAME_BITS-1:0] shiftIn;
  logic [7:0]            nextByte;
  assign nextByte = {shiftIn[6:0], mosiS};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt  <= '0;
      shiftIn <= '0;
    end else if (csS) begin
      bitCnt  <= '0;
    end else if (sclkRise) begin
      shiftIn <= {shiftIn[FRAME_BITS-2:0], mosiS};
      if (bitCnt != CNT_SAT) bitCnt <= bitCnt + 1'b1;
    end
  end

  // Frame-close decode: only an exact bit count counts
  always_comb begin
    evt          = '0;
    evt.wrenStb  = csRise && (bitCnt == CNT_BYTE)  && (shiftIn[7:0] == OP_WREN);
    evt.eraseStb = csRise && (bitCnt == CNT_FRAME) &&
                   (shiftIn[FRAME_BITS-1 -: 8] == OP_SE);
  end
  assign sector = shiftIn[SECT_LSB +: SECT_W];

  logic unusedShiftBits;
  assign unusedShiftBits = ^shiftIn;

  // Status readback shifter
  logic       rdActive;
  logic [7:0] statusShift;
  logic       misoReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdActive    <= 1'b0;
      statusShift <= '0;
      misoReg     <= 1'b0;
    end else if (csS) begin
      rdActive    <= 1'b0;
      misoReg     <= 1'b0;
    end else if (sclkRise && (bitCnt == CNT_LAST) && (nextByte == OP_RDSR)) begin
      rdActive    <= 1'b1;
      statusShift <= statusByte;
    end else if (sclkFall && rdActive) begin
      misoReg     <= statusShift[7];
      statusShift <= {statusShift[6:0], statusShift[7]};
    end
  end

  assign miso = rdActive & misoReg;

endmodule

// File: rtl/eraseCtl.sv
module eraseCtl
  import secErasePkg::*;
#(
  parameter int NUM_SECT     = 32,
  parameter int ERASE_CYCLES = 50000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  frameEvt_t                   evt,
  input  logic [$clog2(NUM_SECT)-1:0] sector,
  input  logic [NUM_SECT-1:0]         hwProt,
  output logic                        eraseReq,
  output logic [$clog2(NUM_SECT)-1:0] eraseSector,
  output logic                        busy,
  output logic [7:0]                  statusByte
);

  localparam int TMR_W = (ERASE_CYCLES > 2) ? $clog2(ERASE_CYCLES) : 1;
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(ERASE_CYCLES - 1);
  localparam logic [TMR_W-1:0] TMR_ONE  = TMR_W'(1);

  logic             wel, wip;
  logic [TMR_W-1:0] timer;
  logic             accept;

  assign accept = evt.eraseStb && wel && !wip && !hwProt[sector];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel         <= 1'b0;
      wip         <= 1'b0;
      timer       <= '0;
      eraseReq    <= 1'b0;
      eraseSector <= '0;
    end else begin
      eraseReq <= 1'b0;
      if (wip) begin
        if (timer == '0) begin
          wip <= 1'b0;
        end else begin
          timer <= timer - 1'b1;
          if (timer == TMR_ONE) wel <= 1'b0;
        end
      end else if (accept) begin
        wip         <= 1'b1;
        timer       <= TMR_LOAD;
        eraseReq    <= 1'b1;
        eraseSector <= sector;
      end else if (evt.wrenStb) begin
        wel <= 1'b1;
      end
    end
  end

  assign busy       = wip;
  assign statusByte = {6'b0, wel, wip};

endmodule

// File: rtl/sectorEraseCtl.sv
module sectorEraseCtl
  import secErasePkg::*;
#(
  parameter int NUM_SECT     = 32,
  parameter int SECT_LSB     = 16,
  parameter int ERASE_CYCLES = 50000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        csN,
  input  logic                        sclk,
  input  logic                        mosi,
  input  logic [NUM_SECT-1:0]         hwProt,
  output logic                        miso,
  output logic                        eraseReq,
  output logic [$clog2(NUM_SECT)-1:0] eraseSector,
  output logic                        busy,
  output logic [7:0]                  statusOut
);

  localparam int SECT_W = $clog2(NUM_SECT);

  frameEvt_t         evt;
  logic [SECT_W-1:0] frameSector;
  logic [7:0]        statusByte;

  spiFrameDp #(
    .NUM_SECT  (NUM_SECT),
    .SECT_LSB  (SECT_LSB),
    .FRAME_BITS(32)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .csN       (csN),
    .sclk      (sclk),
    .mosi      (mosi),
    .statusByte(statusByte),
    .evt       (evt),
    .sector    (frameSector),
    .miso      (miso)
  );

  eraseCtl #(
    .NUM_SECT    (NUM_SECT),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt),
    .sector     (frameSector),
    .hwProt     (hwProt),
    .eraseReq   (eraseReq),
    .eraseSector(eraseSector),
    .busy       (busy),
    .statusByte (statusByte)
  );

  assign statusOut = statusByte;

endmodule

// File: rtl/sectorEraseChk.sv
module sectorEraseChk #(
  parameter int NUM_SECT = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        eraseReq,
  input logic [$clog2(NUM_SECT)-1:0] eraseSector,
  input logic                        busy,
  input logic [7:0]                  statusOut,
  input logic [NUM_SECT-1:0]         hwProt
);

  logic [NUM_SECT-1:0] hwProtQ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hwProtQ <= '0;
    else        hwProtQ <= hwProt;
  end

  assert_req_needs_wel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    eraseReq |-> $past(statusOut[1]));

  assert_req_starts_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eraseReq |-> $rose(busy));

  assert_req_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eraseReq |=> !eraseReq);

  assert_wel_drops_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!statusOut[1] && !$past(statusOut[1])));

  assert_no_protected_erase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eraseReq |-> !hwProtQ[eraseSector]);

  assert_busy_blocks_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !eraseReq);

endmodule

bind sectorEraseCtl sectorEraseChk #(.NUM_SECT(NUM_SECT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .eraseReq   (eraseReq),
  .eraseSector(eraseSector),
  .busy       (busy),
  .statusOut  (statusOut),
  .hwProt     (hwProt)
);

// File: tb/test_sectorEraseCtl.sv
module test_sectorEraseCtl;

  localparam int NUM_SECT     = 32;
  localparam int ERASE_CYCLES = 600;
  localparam int HALF         = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic [NUM_SECT-1:0] hwProt = 32'h0000_0400; // sector 10 protected

  logic       miso, eraseReq, busy;
  logic [4:0] eraseSector;
  logic [7:0] statusOut;

  sectorEraseCtl #(
    .NUM_SECT    (NUM_SECT),
    .SECT_LSB    (16),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) i_sectorEraseCtl (
    .clk(clk), .rst_n(rst_n), .csN(csN), .sclk(sclk), .mosi(mosi),
    .hwProt(hwProt), .miso(miso), .eraseReq(eraseReq),
    .eraseSector(eraseSector), .busy(busy), .statusOut(statusOut)
  );

  always #10 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  task automatic check(input string tag, input logic ok, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int   dueQ[$];
  int   kindQ[$];
  int   secQ[$];
  logic mWel = 1'b0, mWip = 1'b0, mReq = 1'b0;
  int   mTimer = 0;
  int   mSec = 0;

  always @(posedge clk) begin
    logic oldWip;
    cyc = cyc + 1;
    mReq = 1'b0;
    if (!rst_n) begin
      mWel = 1'b0; mWip = 1'b0; mTimer = 0;
    end else begin
      oldWip = mWip;
      if (mWip) begin
        if (mTimer == 0) mWip = 1'b0;
        else begin
          if (mTimer == 1) mWel = 1'b0;
          mTimer = mTimer - 1;
        end
      end
      if (dueQ.size() > 0 && dueQ[0] == cyc) begin
        int k, s;
        k = kindQ.pop_front();
        s = secQ.pop_front();
        void'(dueQ.pop_front());
        if (!oldWip) begin
          if (k == 2 && mWel && !hwProt[s]) begin
            mWip = 1'b1; mTimer = ERASE_CYCLES - 1; mReq = 1'b1; mSec = s;
          end else if (k == 1) begin
            mWel = 1'b1;
          end
        end
      end
    end
  end

  // Per-cycle comparison and run-length monitors
  int   reqSeen = 0;
  int   lastSector = -1;
  int   curRun = 0, lastRun = 0;
  int   busyFellCyc = 0, welFellCyc = 0;
  logic prevBusy = 1'b0, prevWel = 1'b0;

  always @(negedge clk) begin
    if (cyc >= 1) begin
      check("R5 busy vs model", busy === mWip, busy, mWip);
      check("R8 statusOut vs model", statusOut === {6'b0, mWel, mWip}, statusOut, {6'b0, mWel, mWip});
      check("R5 eraseReq vs model", eraseReq === mReq, eraseReq, mReq);
      if (mReq) check("R4 eraseSector vs model", eraseSector === 5'(mSec), eraseSector, mSec);
    end
    if (eraseReq) begin reqSeen++; lastSector = eraseSector; end
    if (busy) curRun++;
    if (!busy && prevBusy) begin lastRun = curRun; curRun = 0; busyFellCyc = cyc; end
    if (!statusOut[1] && prevWel) welFellCyc = cyc;
    prevBusy = busy;
    prevWel  = statusOut[1];
  end

  // Frame driver: value in the low nbits, sent MSB first
  task automatic sendFrame(input logic [39:0] val, input int nbits);
    int kind;
    kind = 0;
    if (nbits == 8 && val[7:0] == 8'h06) kind = 1;
    if (nbits == 32 && val[31:24] == 8'hD8) kind = 2;
    @(negedge clk) csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      mosi = val[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    if (kind != 0) begin
      dueQ.push_back(cyc + 3);
      kindQ.push_back(kind);
      secQ.push_back(int'(val[20:16]));
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic readStatus(input string tag, input logic [7:0] exp);
    logic [7:0] got;
    got = '0;
    @(negedge clk) csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      mosi = 8'h05 >> i;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    for (int i = 0; i < 8; i++) begin
      repeat (HALF) @(negedge clk);
      got = {got[6:0], miso};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (8) @(negedge clk);
    check(tag, got === exp, got, exp);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 4 * ERASE_CYCLES && busy; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state
    check("R10 statusOut after reset", statusOut === 8'h00, statusOut, 0);
    check("R10 busy/eraseReq/miso after reset", {busy, eraseReq, miso} === 3'b000, {busy, eraseReq, miso}, 0);

    // R1: erase without write-enable
    sendFrame({8'h00, 8'hD8, 24'h03_0000}, 32);
    repeat (10) @(negedge clk);
    check("R1 no request without latch", reqSeen == 0, reqSeen, 0);
    check("R1 not busy without latch", busy === 1'b0, busy, 0);

    // R2 and R8: write-enable then read back
    sendFrame(40'h06, 8);
    check("R2 latch set by 06h", statusOut === 8'h02, statusOut, 8'h02);
    readStatus("R8 read-status idle byte", 8'h02);
    check("R8 miso low outside read", miso === 1'b0, miso, 0);

    // R3: wrong bit counts
    sendFrame({9'h0, 31'h6C01_8000}, 31);
    check("R3 31-bit frame ignored", reqSeen == 0 && statusOut === 8'h02, statusOut, 8'h02);
    sendFrame({7'h0, 8'hD8, 24'h03_0000, 1'b1}, 33);
    check("R3 33-bit frame ignored", reqSeen == 0 && statusOut === 8'h02, statusOut, 8'h02);
    sendFrame(40'hD8, 8);
    check("R3 opcode-only frame ignored", reqSeen == 0 && statusOut === 8'h02, statusOut, 8'h02);

    // R7: protected sector 10
    sendFrame({8'h00, 8'hD8, 24'h0A_1234}, 32);
    check("R7 protected sector not erased", reqSeen == 0, reqSeen, 0);
    check("R7 latch kept after protected reject", statusOut === 8'h02, statusOut, 8'h02);

    // R4/R5: good erase, high address bits set, sector 5
    sendFrame({8'h00, 8'hD8, 24'hE5_4321}, 32);
    check("R5 one request issued", reqSeen == 1, reqSeen, 1);
    check("R4 sector from bits 20..16", lastSector == 5, lastSector, 5);
    check("R5 busy during erase", busy === 1'b1, busy, 1);
    readStatus("R8 read-status while busy", 8'h03);

    // R9: erase while busy
    sendFrame({8'h00, 8'hD8, 24'h07_0000}, 32);
    check("R9 erase while busy ignored", reqSeen == 1, reqSeen, 1);
    waitIdle();
    check("R9 cycle length unchanged", lastRun == ERASE_CYCLES, lastRun, ERASE_CYCLES);
    check("R6 latch drops one clock before busy", busyFellCyc - welFellCyc == 1, busyFellCyc - welFellCyc, 1);
    check("R6 latch clear after cycle", statusOut === 8'h00, statusOut, 0);

    // R1 again: latch consumed
    sendFrame({8'h00, 8'hD8, 24'h02_0000}, 32);
    check("R1 second erase needs new write-enable", reqSeen == 1, reqSeen, 1);

    // R4 boundary: top sector 31
    sendFrame(40'h06, 8);
    sendFrame({8'h00, 8'hD8, 24'h1F_FFFF}, 32);
    check("R4 top sector index", lastSector == 31 && reqSeen == 2, lastSector, 31);
    waitIdle();
    check("R5 second cycle length", lastRun == ERASE_CYCLES, lastRun, ERASE_CYCLES);

    finishRun();
  end

endmodule